// File: doc/BRIEF.md
# Sensor PLL Configuration Sequencer

This block holds the clock divisor settings of an image sensor and decides when its PLL runs. A narrow write port loads six settings: the pre-PLL divider, the PLL multiplier, the system clock divider, the output pixel clock divider, a serial signalling-mode select and a pixel-width select. The block presents effective values to a downstream clock generator. In data/strobe signalling the serializer uses both clock edges, so the multiplier sent to the PLL is the programmed value shifted right by one bit, with its least significant bit dropped.

A level command, `stream_req`, moves the block between software standby and streaming. The PLL has no enable bit of its own. It is switched on by leaving standby. Streaming is then held back by a lock-wait counter that runs on the external reference clock. Settings may change only in standby. A write made at any other time is dropped and raises a sticky error flag. A second flag reports a pixel clock divider that does not suit the selected pixel width.

Top module: `pll_cfg_seq`

## Requirements
- R1: While the reset input is held low and after it is released, the block is in standby. The pre-PLL, system and pixel dividers read 0, the multiplier reads MULT_RST (default 32), signalling is data/clock, the format is 10-bit, and `pll_en`, `pll_locked`, `stream_active` and `wr_err` are all 0.
- R2: In standby, a write with `wr_en`=1 updates the setting chosen by `wr_sel` at the next clock edge. The codes are 0 pre-PLL divider, 1 multiplier, 2 system divider, 3 pixel divider, 4 signalling mode (bit 0: 1 = data/strobe) and 5 format (bit 0: 1 = 8-bit). Codes 6 and 7 change nothing.
- R3: In data/strobe signalling, `eff_mult` equals the programmed multiplier shifted right by one bit, so odd and even values one apart give the same result.
- R4: In data/clock signalling, `eff_mult` equals the programmed multiplier unchanged, for both odd and even values.
- R5: `cfg_err` is 1 exactly when the programmed pixel divider differs from 8 in 8-bit format, or from 10 in 10-bit format.
- R6: `pll_en` is 1 from the first cycle after a clock edge samples `stream_req` high in standby, and it stays 1 through locking and streaming.
- R7: `stream_active` and `pll_locked` both rise exactly LOCK_CYCLES (default 6750) reference clock cycles after the edge that sampled the request. They stay low before that.
- R8: A write made while locking or streaming changes no setting and sets `wr_err`. `wr_err` stays at 1 until reset.
- R9: When `stream_req` is low at a clock edge, `pll_en`, `pll_locked` and `stream_active` are low in the next cycle. The lock counter is cleared, so a later request waits the full LOCK_CYCLES again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 3 | Setting select code |
| wr_data | input | DATA_W (16) | Write data, low bits used |
| stream_req | input | 1 | 1 requests streaming, 0 requests standby |
| eff_prediv | output | DIV_W (8) | Effective pre-PLL divider |
| eff_mult | output | MULT_W (12) | Effective multiplier sent to the PLL |
| eff_sysdiv | output | DIV_W (8) | Effective system clock divider |
| eff_pixdiv | output | DIV_W (8) | Effective output pixel clock divider |
| sig_strobe | output | 1 | 1 when data/strobe signalling is selected |
| fmt_8bit | output | 1 | 1 when 8-bit pixels are selected |
| pll_en | output | 1 | PLL enabled (locking or streaming) |
| pll_locked | output | 1 | Lock wait complete |
| stream_active | output | 1 | Streaming active |
| wr_err | output | 1 | Sticky flag for a write attempted outside standby |
| cfg_err | output | 1 | Pixel divider does not suit the pixel width |

## Verification
The assertions assume that `stream_req` is a level that is synchronous to `clk`. They also assume that the reset input is released only after the clock is running. The bench drives every input at the falling edge, so each value is stable at the next rising edge. The bench keeps each write to a single-cycle strobe. The rule that setting values stay fixed after a dropped write covers only the cycle that follows such a write. For that reason the bench reads back the effective outputs after each dropped write, before it makes any accepted one.

// File: rtl/pll_cfg_pkg.sv
`timescale 1ns/1ps
package pll_cfg_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_LOCKING = 2'd1,
    ST_STREAM  = 2'd2
  } seq_state_t;

  localparam logic [2:0] SEL_PREDIV  = 3'd0;
  localparam logic [2:0] SEL_MULT    = 3'd1;
  localparam logic [2:0] SEL_SYSDIV  = 3'd2;
  localparam logic [2:0] SEL_PIXDIV  = 3'd3;
  localparam logic [2:0] SEL_SIGMODE = 3'd4;
  localparam logic [2:0] SEL_FORMAT  = 3'd5;

  localparam int PIXDIV_8BIT  = 8;
  localparam int PIXDIV_10BIT = 10;

endpackage

// File: rtl/pll_rst_sync.sv
`timescale 1ns/1ps
module pll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/pll_cfg_regs.sv
`timescale 1ns/1ps
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MULT_W   = 12,
  parameter int DATA_W   = 16,
  parameter int MULT_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accept,
  output logic [DIV_W-1:0]  eff_prediv,
  output logic [MULT_W-1:0] eff_mult,
  output logic [DIV_W-1:0]  eff_sysdiv,
  output logic [DIV_W-1:0]  eff_pixdiv,
  output logic              sig_strobe,
  output logic              fmt_8bit,
  output logic              wr_err,
  output logic              cfg_err
);

  localparam int NDIV = 3;
  localparam logic [2:0] DIV_SEL [NDIV] = '{SEL_PREDIV, SEL_SYSDIV, SEL_PIXDIV};
  localparam logic [DIV_W-1:0] PIX8  = DIV_W'(PIXDIV_8BIT);
  localparam logic [DIV_W-1:0] PIX10 = DIV_W'(PIXDIV_10BIT);

  logic wr_ok;
  logic wr_bad;
  logic unused_wr_bits;

  logic [DIV_W-1:0]  div_q  [NDIV];
  logic [DIV_W-1:0]  div_d  [NDIV];
  logic [NDIV-1:0]   div_we;
  logic [MULT_W-1:0] mult_q, mult_d;
  logic              mult_we;
  logic              sig_q, sig_d, sig_we;
  logic              fmt_q, fmt_d, fmt_we;
  logic              err_q, err_d;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    wr_ok  = wr_en && accept;
    wr_bad = wr_en && !accept;
  end

  genvar g;
  generate
    for (g = 0; g < NDIV; g++) begin : g_div
      always_comb begin
        div_we[g] = wr_ok && (wr_sel == DIV_SEL[g]);
        div_d[g]  = wr_data[DIV_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q[g] <= '0;
        end else if (div_we[g]) begin
          div_q[g] <= div_d[g];
        end
      end
    end
  endgenerate

  always_comb begin
    mult_we = wr_ok && (wr_sel == SEL_MULT);
    mult_d  = wr_data[MULT_W-1:0];
    sig_we  = wr_ok && (wr_sel == SEL_SIGMODE);
    sig_d   = wr_data[0];
    fmt_we  = wr_ok && (wr_sel == SEL_FORMAT);
    fmt_d   = wr_data[0];
    err_d   = err_q || wr_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= MULT_W'(MULT_RST);
    end else if (mult_we) begin
      mult_q <= mult_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
    end else if (sig_we) begin
      sig_q <= sig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= 1'b0;
    end else if (fmt_we) begin
      fmt_q <= fmt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  // Data/strobe signalling runs the serializer clock at half rate.
  always_comb begin
    if (sig_q) begin
      eff_mult = {1'b0, mult_q[MULT_W-1:1]};
    end else begin
      eff_mult = mult_q;
    end
    eff_prediv = div_q[0];
    eff_sysdiv = div_q[1];
    eff_pixdiv = div_q[2];
    sig_strobe = sig_q;
    fmt_8bit   = fmt_q;
    wr_err     = err_q;
    cfg_err    = fmt_q ? (div_q[2] != PIX8) : (div_q[2] != PIX10);
  end

  AST_IGNORED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(mult_q) && $stable(sig_q) && $stable(fmt_q) &&
                $stable(div_q[0]) && $stable(div_q[1]) && $stable(div_q[2]))); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R8

  AST_BAD_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> err_q); // R8

endmodule

// File: rtl/pll_lock_timer.sv
`timescale 1ns/1ps
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 6750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CNT_W = $clog2(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    if (!run) begin
      cnt_d = '0;
    end else if (!at_last) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = run && at_last;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pll_seq_fsm.sv
`timescale 1ns/1ps
module pll_seq_fsm
  import pll_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stream_req,
  input  logic lock_done,
  output logic in_standby,
  output logic timer_run,
  output logic pll_en,
  output logic pll_locked,
  output logic stream_active
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STANDBY: if (stream_req) state_d = ST_LOCKING;
      ST_LOCKING: begin
        if (!stream_req)    state_d = ST_STANDBY;
        else if (lock_done) state_d = ST_STREAM;
      end
      ST_STREAM:  if (!stream_req) state_d = ST_STANDBY;
      default:    state_d = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STANDBY;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    in_standby    = (state_q == ST_STANDBY);
    timer_run     = (state_q == ST_LOCKING);
    pll_en        = (state_q != ST_STANDBY);
    pll_locked    = (state_q == ST_STREAM);
    stream_active = (state_q == ST_STREAM);
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != seq_state_t'(2'd3)); // R6

  AST_REQ_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && stream_req) |=> pll_en); // R6

endmodule

// File: rtl/pll_cfg_seq.sv
`timescale 1ns/1ps
module pll_cfg_seq
  import pll_cfg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MULT_W      = 12,
  parameter int DATA_W      = 16,
  parameter int MULT_RST    = 32,
  parameter int LOCK_CYCLES = 6750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stream_req,
  output logic [DIV_W-1:0]  eff_prediv,
  output logic [MULT_W-1:0] eff_mult,
  output logic [DIV_W-1:0]  eff_sysdiv,
  output logic [DIV_W-1:0]  eff_pixdiv,
  output logic              sig_strobe,
  output logic              fmt_8bit,
  output logic              pll_en,
  output logic              pll_locked,
  output logic              stream_active,
  output logic              wr_err,
  output logic              cfg_err
);

  logic rst_n_int;
  logic in_standby;
  logic timer_run;
  logic lock_done;

  pll_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  pll_cfg_regs #(
    .DIV_W    (DIV_W),
    .MULT_W   (MULT_W),
    .DATA_W   (DATA_W),
    .MULT_RST (MULT_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .accept     (in_standby),
    .eff_prediv (eff_prediv),
    .eff_mult   (eff_mult),
    .eff_sysdiv (eff_sysdiv),
    .eff_pixdiv (eff_pixdiv),
    .sig_strobe (sig_strobe),
    .fmt_8bit   (fmt_8bit),
    .wr_err     (wr_err),
    .cfg_err    (cfg_err)
  );

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (timer_run),
    .done  (lock_done)
  );

  pll_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .stream_req    (stream_req),
    .lock_done     (lock_done),
    .in_standby    (in_standby),
    .timer_run     (timer_run),
    .pll_en        (pll_en),
    .pll_locked    (pll_locked),
    .stream_active (stream_active)
  );

  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(stream_active) |-> $past(lock_done)); // R7

  AST_EN_COVERS_STREAM: assert property (@(posedge clk) disable iff (!rst_n_int)
    stream_active |-> pll_en); // R6

  AST_STREAM_DROP: assert property (@(posedge clk) disable iff (!rst_n_int)
    !stream_req |=> (!stream_active && !pll_locked && !pll_en)); // R9

endmodule

// File: tb/pll_cfg_seq_test.sv
`timescale 1ns/1ps
module pll_cfg_seq_test;

  localparam int LOCK = 6750;
  localparam int NV   = 8;

  // {mode, mult[11:0], fmt8, pix[7:0], exp_mult[11:0], exp_cfg_err}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 12'd641,  1'b0, 8'd10, 12'd641,  1'b0},
    {1'b1, 12'd641,  1'b1, 8'd8,  12'd320,  1'b0},
    {1'b1, 12'd640,  1'b1, 8'd10, 12'd320,  1'b1},
    {1'b0, 12'd640,  1'b0, 8'd8,  12'd640,  1'b1},
    {1'b1, 12'd1,    1'b0, 8'd10, 12'd0,    1'b0},
    {1'b0, 12'd4095, 1'b1, 8'd8,  12'd4095, 1'b0},
    {1'b1, 12'd4095, 1'b0, 8'd0,  12'd2047, 1'b1},
    {1'b0, 12'd0,    1'b1, 8'd9,  12'd0,    1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        stream_req;
  logic [7:0]  eff_prediv, eff_sysdiv, eff_pixdiv;
  logic [11:0] eff_mult;
  logic        sig_strobe, fmt_8bit, pll_en, pll_locked, stream_active, wr_err, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  pll_cfg_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stream_req(stream_req), .eff_prediv(eff_prediv), .eff_mult(eff_mult),
    .eff_sysdiv(eff_sysdiv), .eff_pixdiv(eff_pixdiv), .sig_strobe(sig_strobe),
    .fmt_8bit(fmt_8bit), .pll_en(pll_en), .pll_locked(pll_locked),
    .stream_active(stream_active), .wr_err(wr_err), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; stream_req = 1'b0;
    do_reset();

    // R1 reset state
    check("R1 prediv", int'(eff_prediv), 0);
    check("R1 sysdiv", int'(eff_sysdiv), 0);
    check("R1 pixdiv", int'(eff_pixdiv), 0);
    check("R1 mult", int'(eff_mult), 32);
    check("R1 strobe", int'(sig_strobe), 0);
    check("R1 fmt8", int'(fmt_8bit), 0);
    check("R1 pll_en", int'(pll_en), 0);
    check("R1 locked", int'(pll_locked), 0);
    check("R1 active", int'(stream_active), 0);
    check("R1 wr_err", int'(wr_err), 0);

    // Vector table: R3 / R4 multiplier adjustment, R5 format check
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, {15'd0, VEC[i][34]});
      wr(3'd1, {4'd0, VEC[i][33:22]});
      wr(3'd5, {15'd0, VEC[i][21]});
      wr(3'd3, {8'd0, VEC[i][20:13]});
      check(VEC[i][34] ? "R3 strobe mult" : "R4 clock mult", int'(eff_mult), int'(VEC[i][12:1]));
      check("R5 cfg_err", int'(cfg_err), int'(VEC[i][0]));
    end

    // R2 other selects, and unused codes
    wr(3'd0, 16'd3);
    wr(3'd2, 16'd5);
    check("R2 prediv", int'(eff_prediv), 3);
    check("R2 sysdiv", int'(eff_sysdiv), 5);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    check("R2 unused code prediv", int'(eff_prediv), 3);
    check("R2 unused code sysdiv", int'(eff_sysdiv), 5);
    check("R2 unused code pixdiv", int'(eff_pixdiv), 9);
    check("R2 unused code mult", int'(eff_mult), 0);
    check("R2 unused code fmt", int'(fmt_8bit), 1);
    check("R2 no error in standby", int'(wr_err), 0);

    // Known config: strobe, mult 640, 10-bit, pix 10
    wr(3'd4, 16'd1);
    wr(3'd1, 16'd640);
    wr(3'd5, 16'd0);
    wr(3'd3, 16'd10);

    // R6 / R7 lock wait
    @(negedge clk); stream_req = 1'b1;
    @(negedge clk);
    check("R6 pll_en after request", int'(pll_en), 1);
    check("R7 active early", int'(stream_active), 0);
    // R8 write during locking is dropped
    wr(3'd1, 16'd7);
    check("R8 locking write dropped", int'(eff_mult), 320);
    check("R8 err after locking write", int'(wr_err), 1);
    repeat (LOCK - 3) @(negedge clk);
    check("R7 active one cycle early", int'(stream_active), 0);
    check("R7 locked one cycle early", int'(pll_locked), 0);
    @(negedge clk);
    check("R7 active on time", int'(stream_active), 1);
    check("R7 locked on time", int'(pll_locked), 1);
    check("R6 pll_en while streaming", int'(pll_en), 1);

    // R8 writes while streaming
    wr(3'd4, 16'd0);
    check("R8 mode write dropped", int'(eff_mult), 320);
    wr(3'd3, 16'd8);
    check("R8 pix write dropped", int'(eff_pixdiv), 10);
    check("R8 sticky", int'(wr_err), 1);

    // R9 back to standby
    @(negedge clk); stream_req = 1'b0;
    @(negedge clk);
    check("R9 active cleared", int'(stream_active), 0);
    check("R9 locked cleared", int'(pll_locked), 0);
    check("R9 pll_en cleared", int'(pll_en), 0);
    check("R8 sticky after standby", int'(wr_err), 1);
    wr(3'd1, 16'd101);
    check("R2 accepted after return", int'(eff_mult), 50);

    // R9 abort during locking clears the counter
    @(negedge clk); stream_req = 1'b1;
    repeat (200) @(negedge clk);
    stream_req = 1'b0;
    @(negedge clk);
    check("R9 abort drops pll_en", int'(pll_en), 0);
    stream_req = 1'b1;
    @(negedge clk);
    repeat (LOCK - 1) @(negedge clk);
    check("R9 full wait after abort", int'(stream_active), 0);
    @(negedge clk);
    check("R7 active after restart", int'(stream_active), 1);

    // R1 reset while streaming
    stream_req = 1'b0;
    do_reset();
    check("R1 reset clears err", int'(wr_err), 0);
    check("R1 reset clears mult", int'(eff_mult), 32);
    check("R1 reset stops stream", int'(stream_active), 0);

    finish_run();
  end

endmodule